// File: doc/BRIEF.md
# Broadcast Outer-Product Matrix Tile

This block computes a DIM×DIM tile of a matrix product C = A·B with a grid of multiply-accumulate nodes that keep their results in place. On each accepted step the caller presents one column of an A row-slice, which is DIM signed 16-bit values, and one row of a B column-slice, also DIM signed 16-bit values. Each A value is broadcast along one grid row. Each B value is broadcast along one grid column. Node (i,j) multiplies A lane i by B lane j and adds the product to its own 32-bit partial sum. A step can therefore reuse one loaded operand across DIM nodes. There is no skewing and no operand shifting between neighbours.

The caller marks the first step of a tile with a clear flag and the last step with a last flag, so the shared dimension can have any length. After the last step the block drains the tile one row per cycle. Each element is narrowed to 16 bits after an arithmetic right shift, and the shift amount is captured together with the last step. New steps are refused until the drain has finished. With the default DIM of 4, a 16×16 result takes sixteen tiles, which the surrounding logic sequences.

Top module: `outer_tile_mac`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A step is accepted when in_valid_i and in_ready_o are both 1. On an accepted step with clear_i=1, every partial sum is replaced by that step's product. Without clear_i, the product is added to the partial sum.
- R3: Lane k of a vector port occupies bits [16k+15:16k] as a two's-complement value. Node (i,j) uses A lane i and B lane j. In the drain, row i, column j appears in lane j of out_data_o.
- R4: Partial sums are 32-bit signed and saturate at 2147483647 and -2147483648 instead of wrapping.
- R5: Each output element is the partial sum shifted right arithmetically by the captured shift amount, then clamped to the range -32768..32767.
- R6: An accepted step with last_i=1 starts a drain in the next cycle. The drain asserts out_valid_o for exactly DIM consecutive cycles, with out_row_o counting 0..DIM-1 in order.
- R7: in_ready_o is 0 during the drain. Steps offered in that window change no partial sum, and the partial sums carry over to the next tile unless clear_i is set.
- R8: Cycles with in_valid_i=0 leave every partial sum unchanged, whatever values the vector inputs hold.
- R9: The shift amount is sampled on the accepted last step. Changing shift_i during the drain does not affect the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A step is offered |
| clear_i | input | 1 | First step of a tile: restart the sums |
| last_i | input | 1 | Final step of a tile: drain afterwards |
| shift_i | input | 5 | Right shift applied at output |
| a_vec_i | input | 64 | A column, DIM lanes of 16 bits |
| b_vec_i | input | 64 | B row, DIM lanes of 16 bits |
| in_ready_o | output | 1 | Steps accepted |
| out_valid_o | output | 1 | Drain row present |
| out_row_o | output | 2 | Index of the row being drained |
| out_data_o | output | 64 | Row results, DIM lanes of 16 bits |

## Verification
A corrupted partial sum stays hidden until the next drain. It then appears as a wrong lane value in the row and column of the faulty node, in the first drain after the fault, so each tile is checked element by element against a model built from the requirements. A fault in the drain sequencer appears immediately as a missing or extra valid cycle, a row out of order, or in_ready_o asserted too early. Operands offered while the block is busy or idle are driven with nonzero values. Their effect is then observed by continuing the same tile without clear, so a leak shows up at the ports in the next drain.

// File: rtl/otile_pkg.sv
package otile_pkg;
  typedef enum logic {ST_ACC, ST_DRAIN} drain_st_e;
endpackage

// File: rtl/otile_mac_node.sv
module otile_mac_node #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic signed [OP_W-1:0]  a_i,
  input  logic signed [OP_W-1:0]  b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W:0]   base_ext, prod_ext, sum;
  logic signed [ACC_W-1:0] sum_sat;

  assign prod     = a_i * b_i;
  assign base_ext = clr_i ? '0 : {acc_o[ACC_W-1], acc_o};
  assign prod_ext = {{(ACC_W + 1 - PW){prod[PW-1]}}, prod};
  assign sum      = base_ext + prod_ext;

  // overflow when the two top bits disagree
  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1])
      sum_sat = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      sum_sat = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= sum_sat;
  end
endmodule

// File: rtl/otile_narrow.sv
module otile_narrow #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32,
  parameter int SH_W  = 5
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic [OP_W-1:0]         res_o
);
  logic signed [ACC_W-1:0] sh;
  logic [ACC_W-OP_W:0]     hi;

  assign sh = acc_i >>> shift_i;
  assign hi = sh[ACC_W-1:OP_W-1];

  always_comb begin
    if ((&hi) || !(|hi)) res_o = sh[OP_W-1:0];
    else if (sh[ACC_W-1]) res_o = {1'b1, {(OP_W-1){1'b0}}};
    else                  res_o = {1'b0, {(OP_W-1){1'b1}}};
  end
endmodule

// File: rtl/otile_drain_ctrl.sv
module otile_drain_ctrl
  import otile_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_last_i,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] ROW_END = ROW_W'(DIM - 1);

  drain_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ACC;
      row_o <= '0;
    end else begin
      case (st_q)
        ST_ACC: if (fire_last_i) begin
          st_q  <= ST_DRAIN;
          row_o <= '0;
        end
        ST_DRAIN: begin
          if (row_o == ROW_END) begin
            st_q  <= ST_ACC;
            row_o <= '0;
          end else begin
            row_o <= row_o + 1'b1;
          end
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end

  assign busy_o = (st_q == ST_DRAIN);
endmodule

// File: rtl/outer_tile_mac.sv
module outer_tile_mac #(
  parameter int DIM   = 4,
  parameter int OP_W  = 16,
  parameter int ACC_W = 32,
  parameter int SH_W  = 5,
  parameter int ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic                  clear_i,
  input  logic                  last_i,
  input  logic [SH_W-1:0]       shift_i,
  input  logic [DIM*OP_W-1:0]   a_vec_i,
  input  logic [DIM*OP_W-1:0]   b_vec_i,
  output logic                  in_ready_o,
  output logic                  out_valid_o,
  output logic [ROW_W-1:0]      out_row_o,
  output logic [DIM*OP_W-1:0]   out_data_o
);
  logic                    busy, fire;
  logic [SH_W-1:0]         shift_q;
  logic signed [ACC_W-1:0] acc [DIM][DIM];
  logic signed [ACC_W-1:0] row_sel [DIM];

  assign in_ready_o = !busy;
  assign fire       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               shift_q <= '0;
    else if (fire && last_i)   shift_q <= shift_i;
  end

  otile_drain_ctrl #(.DIM(DIM), .ROW_W(ROW_W)) i_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_last_i(fire && last_i),
    .busy_o     (busy),
    .row_o      (out_row_o)
  );

  for (genvar gi = 0; gi < DIM; gi++) begin : g_row
    for (genvar gj = 0; gj < DIM; gj++) begin : g_col
      otile_mac_node #(.OP_W(OP_W), .ACC_W(ACC_W)) i_node (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (fire),
        .clr_i (clear_i),
        .a_i   (a_vec_i[gi*OP_W +: OP_W]),
        .b_i   (b_vec_i[gj*OP_W +: OP_W]),
        .acc_o (acc[gi][gj])
      );
    end
  end

  for (genvar gj = 0; gj < DIM; gj++) begin : g_out
    assign row_sel[gj] = acc[out_row_o][gj];
    otile_narrow #(.OP_W(OP_W), .ACC_W(ACC_W), .SH_W(SH_W)) i_narrow (
      .acc_i  (row_sel[gj]),
      .shift_i(shift_q),
      .res_o  (out_data_o[gj*OP_W +: OP_W])
    );
  end

  assign out_valid_o = busy;
endmodule

// File: rtl/outer_tile_mac_chk.sv
module outer_tile_mac_chk #(
  parameter int DIM   = 4,
  parameter int ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             last_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [ROW_W-1:0] out_row_o
);
  localparam logic [ROW_W-1:0] ROW_END = ROW_W'(DIM - 1);

  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_last_starts_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && last_i) |=> (out_valid_o && out_row_o == '0));

  assert_row_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_row_o != ROW_END) |=> (out_valid_o && out_row_o == $past(out_row_o) + 1'b1));

  assert_drain_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_row_o == ROW_END) |=> (!out_valid_o && in_ready_o));

  assert_drain_from_row0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_row_o == '0);
endmodule

bind outer_tile_mac outer_tile_mac_chk #(.DIM(DIM), .ROW_W(ROW_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .last_i     (last_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_row_o  (out_row_o)
);

// File: tb/test_outer_tile_mac.sv
module test_outer_tile_mac;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 4;
  localparam int OP_W = 16;
  localparam int NSTEP = 8;

  localparam logic [63:0] TBL_A [NSTEP] = '{
    64'h0001_0002_0003_0004, 64'hFFFF_0005_FFFE_0007,
    64'h0100_FF00_0010_0020, 64'h7FFF_8000_0001_0000,
    64'h1234_0ABC_F00D_0042, 64'h0003_0003_0003_0003,
    64'hFFF0_0010_FFF0_0010, 64'h0000_0001_0000_0001};
  localparam logic [63:0] TBL_B [NSTEP] = '{
    64'h0004_0003_0002_0001, 64'h0002_FFFD_0006_FFFF,
    64'h0010_0010_FF80_0040, 64'h0002_0002_7FFF_8000,
    64'h0011_FFEE_0100_0009, 64'hFFFF_0002_FFFD_0004,
    64'h0020_0020_FFE0_0020, 64'h1000_0000_2000_0000};
  localparam logic [4:0] TBL_SH [2] = '{5'd2, 5'd0};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, clr = 0, last = 0;
  logic [4:0] shift = 0;
  logic [63:0] a_vec = 0, b_vec = 0;
  logic in_ready, out_valid;
  logic [1:0] out_row;
  logic [63:0] out_data;

  longint mdl [DIM][DIM];
  int mdl_sh;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outer_tile_mac i_outer_tile_mac (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .clear_i(clr),
    .last_i(last), .shift_i(shift), .a_vec_i(a_vec), .b_vec_i(b_vec),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_row_o(out_row),
    .out_data_o(out_data));

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane(logic [63:0] v, int k);
    logic signed [15:0] t;
    t = v[k*16 +: 16];
    return longint'(t);
  endfunction

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint narrow(longint acc, int sh);
    longint t;
    t = acc >>> sh;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  // drive one step starting at a negedge; model follows R2/R3/R4
  task automatic step(logic [63:0] a, logic [63:0] b, bit c, bit l, logic [4:0] sh);
    chk(in_ready == 1'b1, "R7 ready before step", longint'(in_ready), 1);
    in_valid = 1; a_vec = a; b_vec = b; clr = c; last = l; shift = sh;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++)
        mdl[i][j] = sat32((c ? 64'sd0 : mdl[i][j]) + lane(a, i) * lane(b, j));
    if (l) mdl_sh = int'(sh);
    @(negedge clk);
    in_valid = 0; clr = 0; last = 0;
  endtask

  // R8: idle cycles with garbage on the vectors
  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      a_vec = 64'h7FFF_7FFF_7FFF_7FFF; b_vec = 64'h8000_1234_8000_4321;
      @(negedge clk);
    end
  endtask

  task automatic drain(bit junk);
    for (int r = 0; r < DIM; r++) begin
      chk(out_valid == 1'b1, "R6 valid in drain", longint'(out_valid), 1);
      chk(out_row == 2'(r), "R6 row order", longint'(out_row), r);
      chk(in_ready == 1'b0, "R7 not ready in drain", longint'(in_ready), 0);
      for (int j = 0; j < DIM; j++)
        chk(lane(out_data, j) == narrow(mdl[r][j], mdl_sh), "R3 R5 drain data",
            lane(out_data, j), narrow(mdl[r][j], mdl_sh));
      if (junk) begin
        in_valid = 1; clr = 1; last = 1;  // R7 ignored step, R9 shift change
        a_vec = 64'h7FFF_7FFF_7FFF_7FFF; b_vec = 64'h7FFF_7FFF_7FFF_7FFF;
        shift = 5'd31;
      end
      @(negedge clk);
    end
    in_valid = 0; clr = 0; last = 0;
    chk(out_valid == 1'b0, "R6 drain length", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 ready after drain", longint'(in_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DIM; i++) for (int j = 0; j < DIM; j++) mdl[i][j] = 0;
    mdl_sh = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 reset ready", longint'(in_ready), 1);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R2 R3 R5: table walk, two tiles of four steps
    for (int idx = 0; idx < NSTEP; idx++) begin
      step(TBL_A[idx], TBL_B[idx], (idx % 4) == 0, (idx % 4) == 3, TBL_SH[idx / 4]);
      if (idx % 4 == 3) drain(1'b0);
    end

    // R8: gaps between steps
    step(64'h0002_0003_FFFF_0004, 64'h0005_0006_0007_FFF8, 1, 0, 0);
    idle(3);
    step(64'h0010_0001_0001_0001, 64'h0001_0010_0001_0001, 0, 0, 0);
    idle(2);
    step(64'h0001_0001_0001_0001, 64'h0003_0003_0003_0003, 0, 1, 5'd1);
    drain(1'b1);
    // R7 R9: steps offered during the drain are refused; sums carry over
    step(64'h0001_0002_0003_0004, 64'h0001_0001_0001_0001, 0, 1, 5'd0);
    drain(1'b0);

    // R4 R5: positive saturation, clamped output
    for (int k = 0; k < 3; k++)
      step(64'h7FFF_7FFF_7FFF_0001, 64'h7FFF_7FFF_0001_7FFF, k == 0, k == 2, 5'd0);
    drain(1'b0);
    // R4 R5: negative saturation, large shift
    for (int k = 0; k < 3; k++)
      step(64'h8000_8000_8000_8000, 64'h7FFF_0001_7FFF_8000, k == 0, k == 2, 5'd16);
    drain(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule